// File: doc/BRIEF.md
# TDM Highway Frame Alignment Timing

This block produces the bit and time-slot timing for a set of serial TDM highways that share one frame. It runs on a free-running clock at twice the line clock rate. The input `ck_ph` marks which half of the line clock each tick stands for, so every offset can be placed to half a line-clock period. A frame sync input is sampled on the chosen line-clock edge with the chosen polarity. The first active sample after an inactive one marks the frame boundary.

Each receive and each transmit highway has its own timing generator with its own settings: a data rate of CK/1, CK/2 or CK/4, a time-slot offset, a bit offset and a quarter-bit fractional offset. Every generator reports the current slot and bit index. A receive highway also gives a sample strobe. A transmit highway gives a shift strobe and serial data taken MSB first from a parallel byte that the user supplies for the current slot.

A small state machine tracks alignment. It has two states. `ST_HUNT` is entered from reset and keeps all outputs quiet. `ST_LOCK` is entered through the transition "first frame start", taken when the first sync edge is detected. While in `ST_LOCK`, a sync edge that is off the frame boundary takes the transition "realign". This transition stays in `ST_LOCK`, reloads every counter and raises `misalign` for one tick.

Top module: `tdm_frame_align`

## Requirements
- R1: The sync is active when `fs` equals `fs_pol`, where 1 means active-high. A frame start is a sampled-active sync whose previous sample was inactive. The previous sample is taken as inactive after reset.
- R2: The sync is sampled only on ticks where `ck_ph` equals `fs_rise`, where `ck_ph`=1 marks the rising line-clock edge. `frm_start` pulses on that tick.
- R3: With zero offsets, a receive highway shows slot 0, bit 0 and `rx_smp`=1 on the frame-start tick itself.
- R4: With zero offsets, a transmit highway shows slot 0, bit 0 and `tx_shift`=1 on the frame-start tick. `txd` equals `tx_byte[7 - bit index]`, so bit index 0 carries the MSB. `txd` is 0 before lock.
- R5: Each highway's delay is D = (slot_off*8 + bit_off)*T + floor(frac*T/4) ticks, with D below the frame length. Slot 0, bit 0 falls D ticks after the frame start. No highway's settings affect another highway.
- R6: The rate code 0/1/2 gives T = 2/4/8 ticks per bit, meaning CK/1, CK/2 and CK/4. Code 3 acts as 2. The bit index advances every T ticks and the slot index advances every 8 bits. Strobes fire on the first tick of each bit.
- R7: The fractional offset is in quarter bits. At CK/2, frac=3 places the sample 3 ticks (1.5 CK) after the frame start. At CK/4, bit_off=1 delays the start by 8 ticks (4 CK).
- R8: A frame start while locked that is not a whole number of frames (2*`frm_len` ticks) after the previous one raises `misalign` for that one tick. All counters realign to it.
- R9: Before the first frame start, all strobes, indices and `txd` are 0.
- R10: Each highway wraps to slot 0, bit 0 every 2*`frm_len` ticks. `frm_len` is counted in CK cycles and must be a multiple of 32.
- R11: `locked` is 0 after reset, goes to 1 on the tick after the first frame start, and stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock at twice the line-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ck_ph | input | 1 | Line-clock phase of this tick (1 = rising edge) |
| fs | input | 1 | Frame sync |
| fs_pol | input | 1 | Sync polarity, 1 = active-high |
| fs_rise | input | 1 | Sync sampling edge, 1 = rising |
| frm_len | input | FW | Frame length in line-clock cycles |
| rx_rate | input | NRX x 2 | Receive rate code per highway |
| rx_slot_off | input | NRX x SW | Receive slot offset |
| rx_bit_off | input | NRX x 3 | Receive bit offset |
| rx_frac | input | NRX x 2 | Receive quarter-bit offset |
| tx_rate | input | NTX x 2 | Transmit rate code per highway |
| tx_slot_off | input | NTX x SW | Transmit slot offset |
| tx_bit_off | input | NTX x 3 | Transmit bit offset |
| tx_frac | input | NTX x 2 | Transmit quarter-bit offset |
| tx_byte | input | NTX x 8 | Byte to send in the current slot |
| locked | output | 1 | Alignment state is `ST_LOCK` |
| frm_start | output | 1 | Frame start detected this tick |
| misalign | output | 1 | Off-boundary frame start this tick |
| rx_slot | output | NRX x SW | Receive slot index |
| rx_bit | output | NRX x 3 | Receive bit index |
| rx_smp | output | NRX | Receive sample strobe |
| tx_slot | output | NTX x SW | Transmit slot index |
| tx_bit | output | NTX x 3 | Transmit bit index |
| tx_shift | output | NTX | Transmit shift strobe |
| txd | output | NTX | Transmit serial data |

## Verification
The strobes, indices, `txd`, `frm_start` and `misalign` are all combinational from the current tick's inputs and the counter state. They are therefore due in the same tick as the sync sample that causes them. `locked` is due one tick later. The bench changes inputs one time unit after the rising edge and compares every output at the following falling edge. The expectations come from a tick-level model that counts ticks since the last frame start and applies the delay formula of R5. Each compare therefore lands on the tick the requirement names.

// File: rtl/tdm_align_pkg.sv
package tdm_align_pkg;
    typedef enum logic {ST_HUNT = 1'b0, ST_LOCK = 1'b1} sync_st_e;

    // log2 of ticks per bit for a rate code
    function automatic logic [1:0] rate_log2(input logic [1:0] code);
        unique case (code)
            2'd0:    rate_log2 = 2'd1;
            2'd1:    rate_log2 = 2'd2;
            default: rate_log2 = 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/tdm_sync_det.sv
module tdm_sync_det
    import tdm_align_pkg::*;
#(
    parameter int FW = 12,
    parameter int CW = FW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ck_ph,
    input  logic          fs,
    input  logic          fs_pol,
    input  logic          fs_rise,
    input  logic [CW-1:0] ft,
    output logic          frm_start,
    output logic          locked,
    output logic          misalign
);
    sync_st_e      state, state_nx;
    logic          prev_act;
    logic          samp, act;
    logic [CW-1:0] gcnt, gcur;

    always_comb begin
        samp      = (ck_ph == fs_rise);
        act       = (fs == fs_pol);
        frm_start = samp && act && !prev_act;
        gcur      = frm_start ? '0 : gcnt;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT: if (frm_start) state_nx = ST_LOCK;   // first frame start
            ST_LOCK: state_nx = ST_LOCK;                  // realign stays here
            default: state_nx = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        locked   = 1'b0;
        misalign = 1'b0;
        unique case (state)
            ST_HUNT: ;
            ST_LOCK: begin
                locked   = 1'b1;
                misalign = frm_start && (gcnt != '0);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_act <= 1'b0;
            gcnt     <= '0;
        end else begin
            if (samp) prev_act <= act;
            gcnt <= (gcur == ft - CW'(1)) ? '0 : gcur + CW'(1);
        end
    end
endmodule

// File: rtl/tdm_lane.sv
module tdm_lane
    import tdm_align_pkg::*;
#(
    parameter int CW = 13,
    parameter int SW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_start,
    input  logic          run,
    input  logic [CW-1:0] ft,
    input  logic [1:0]    rate,
    input  logic [SW-1:0] slot_off,
    input  logic [2:0]    bit_off,
    input  logic [1:0]    frac,
    output logic [SW-1:0] slot_idx,
    output logic [2:0]    bit_idx,
    output logic          strobe
);
    logic [1:0]    lg;
    logic [2:0]    lg_slot;
    logic [CW-1:0] dly, load, cnt, cur, mask;

    always_comb begin
        lg       = rate_log2(rate);
        lg_slot  = 3'(lg) + 3'd3;
        dly      = (CW'(slot_off) << lg_slot) + (CW'(bit_off) << lg)
                 + ((CW'(frac) << lg) >> 2);
        load     = (dly == '0) ? '0 : ft - dly;
        cur      = frm_start ? load : cnt;
        mask     = (CW'(1) << lg) - CW'(1);
        slot_idx = run ? SW'(cur >> lg_slot) : '0;
        bit_idx  = run ? 3'(cur >> lg) : 3'd0;
        strobe   = run && ((cur & mask) == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= (cur == ft - CW'(1)) ? '0 : cur + CW'(1);
    end
endmodule

// File: rtl/tdm_frame_align.sv
module tdm_frame_align
    import tdm_align_pkg::*;
#(
    parameter int NRX = 2,
    parameter int NTX = 2,
    parameter int FW  = 12,
    parameter int SW  = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ck_ph,
    input  logic                     fs,
    input  logic                     fs_pol,
    input  logic                     fs_rise,
    input  logic [FW-1:0]            frm_len,
    input  logic [NRX-1:0][1:0]      rx_rate,
    input  logic [NRX-1:0][SW-1:0]   rx_slot_off,
    input  logic [NRX-1:0][2:0]      rx_bit_off,
    input  logic [NRX-1:0][1:0]      rx_frac,
    input  logic [NTX-1:0][1:0]      tx_rate,
    input  logic [NTX-1:0][SW-1:0]   tx_slot_off,
    input  logic [NTX-1:0][2:0]      tx_bit_off,
    input  logic [NTX-1:0][1:0]      tx_frac,
    input  logic [NTX-1:0][7:0]      tx_byte,
    output logic                     locked,
    output logic                     frm_start,
    output logic                     misalign,
    output logic [NRX-1:0][SW-1:0]   rx_slot,
    output logic [NRX-1:0][2:0]      rx_bit,
    output logic [NRX-1:0]           rx_smp,
    output logic [NTX-1:0][SW-1:0]   tx_slot,
    output logic [NTX-1:0][2:0]      tx_bit,
    output logic [NTX-1:0]           tx_shift,
    output logic [NTX-1:0]           txd
);
    localparam int CW = FW + 1;

    logic [CW-1:0] ft;
    logic          run;

    assign ft  = {frm_len, 1'b0};
    assign run = locked || frm_start;

    tdm_sync_det #(.FW(FW), .CW(CW)) i_sync (
        .clk, .rst_n, .ck_ph, .fs, .fs_pol, .fs_rise, .ft,
        .frm_start, .locked, .misalign
    );

    for (genvar gi = 0; gi < NRX; gi++) begin : g_rx
        tdm_lane #(.CW(CW), .SW(SW)) i_lane (
            .clk, .rst_n, .frm_start, .run, .ft,
            .rate(rx_rate[gi]), .slot_off(rx_slot_off[gi]),
            .bit_off(rx_bit_off[gi]), .frac(rx_frac[gi]),
            .slot_idx(rx_slot[gi]), .bit_idx(rx_bit[gi]), .strobe(rx_smp[gi])
        );
    end

    for (genvar gt = 0; gt < NTX; gt++) begin : g_tx
        tdm_lane #(.CW(CW), .SW(SW)) i_lane (
            .clk, .rst_n, .frm_start, .run, .ft,
            .rate(tx_rate[gt]), .slot_off(tx_slot_off[gt]),
            .bit_off(tx_bit_off[gt]), .frac(tx_frac[gt]),
            .slot_idx(tx_slot[gt]), .bit_idx(tx_bit[gt]), .strobe(tx_shift[gt])
        );
        // MSB first: bit index 0 carries byte bit 7
        assign txd[gt] = run && tx_byte[gt][3'd7 - tx_bit[gt]];
    end
endmodule

// File: rtl/tdm_frame_align_chk.sv
module tdm_frame_align_chk #(
    parameter int NRX = 2,
    parameter int NTX = 2,
    parameter int SW  = 9
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   locked,
    input logic                   frm_start,
    input logic                   misalign,
    input logic [NRX-1:0][SW-1:0] rx_slot,
    input logic [NRX-1:0][2:0]    rx_bit,
    input logic [NRX-1:0]         rx_smp,
    input logic [NTX-1:0][2:0]    tx_bit,
    input logic [NTX-1:0]         tx_shift,
    input logic [NTX-1:0]         txd
);
    p_mis_needs_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> frm_start);
    p_mis_when_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> locked);
    p_lock_after_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start |=> locked);
    p_lock_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    for (genvar gi = 0; gi < NRX; gi++) begin : g_rx
        p_rx_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!locked && !frm_start) |-> (!rx_smp[gi] && rx_slot[gi] == '0));
        p_rx_bit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (locked && !frm_start && !rx_smp[gi]) |-> $stable(rx_bit[gi]));
    end

    for (genvar gt = 0; gt < NTX; gt++) begin : g_tx
        p_tx_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!locked && !frm_start) |-> (!txd[gt] && !tx_shift[gt]));
        p_tx_bit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (locked && !frm_start && !tx_shift[gt]) |-> $stable(tx_bit[gt]));
    end
endmodule

bind tdm_frame_align tdm_frame_align_chk #(.NRX(NRX), .NTX(NTX), .SW(SW)) i_chk (
    .clk, .rst_n, .locked, .frm_start, .misalign, .rx_slot, .rx_bit, .rx_smp,
    .tx_bit, .tx_shift, .txd
);

// File: tb/test_tdm_frame_align.sv
module test_tdm_frame_align;
    localparam int NRX = 2, NTX = 2, FW = 12, SW = 9;

    logic clk = 1'b0, rst_n = 1'b0, ck_ph = 1'b0, fs = 1'b0, fs_pol = 1'b1, fs_rise = 1'b1;
    logic [FW-1:0] frm_len = FW'(32);
    logic [NRX-1:0][1:0]    rx_rate = '0, rx_frac = '0;
    logic [NRX-1:0][SW-1:0] rx_slot_off = '0;
    logic [NRX-1:0][2:0]    rx_bit_off = '0;
    logic [NTX-1:0][1:0]    tx_rate = '0, tx_frac = '0;
    logic [NTX-1:0][SW-1:0] tx_slot_off = '0;
    logic [NTX-1:0][2:0]    tx_bit_off = '0;
    logic [NTX-1:0][7:0]    tx_byte = '0;
    logic locked, frm_start, misalign;
    logic [NRX-1:0][SW-1:0] rx_slot;
    logic [NRX-1:0][2:0]    rx_bit;
    logic [NRX-1:0]         rx_smp;
    logic [NTX-1:0][SW-1:0] tx_slot;
    logic [NTX-1:0][2:0]    tx_bit;
    logic [NTX-1:0]         tx_shift, txd;

    int checks = 0, errors = 0;
    int m_t, mis_seen;
    bit m_locked, m_prev;

    always #4 clk = ~clk;

    tdm_frame_align #(.NRX(NRX), .NTX(NTX), .FW(FW), .SW(SW)) i_tdm_frame_align (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int f_tpb(input int rate);
        return (rate >= 2) ? 8 : (2 << rate);
    endfunction

    function automatic int f_dly(input int rate, input int so, input int bo, input int fr);
        int tpb = f_tpb(rate);
        return so * 8 * tpb + bo * tpb + (fr * tpb) / 4;
    endfunction

    // cur position of a lane given ticks since frame start
    function automatic int f_cur(input int t, input int d, input int ft);
        return (((t - d) % ft) + ft) % ft;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        fs = ~fs_pol;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 R11 reset locked", int'(locked), 0);
        chk("R9 reset rx_smp", int'(rx_smp), 0);
        chk("R9 reset txd", int'(txd), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        m_t = 0; m_locked = 0; m_prev = 0; mis_seen = 0;
    endtask

    // run n ticks; sync held active for 2 ticks from each start (-1 = none)
    task automatic run_ticks(input int n, input int s0, input int s1, input int s2);
        int ft = 2 * int'(frm_len);
        for (int tk = 0; tk < n; tk++) begin
            bit win, samp, act, ev, run;
            int tu;
            @(posedge clk); #1;
            ck_ph = ~ck_ph;
            win = (s0 >= 0 && (tk == s0 || tk == s0 + 1)) ||
                  (s1 >= 0 && (tk == s1 || tk == s1 + 1)) ||
                  (s2 >= 0 && (tk == s2 || tk == s2 + 1));
            fs = win ? fs_pol : ~fs_pol;
            @(negedge clk);
            samp = (ck_ph == fs_rise);
            act  = (fs == fs_pol);
            ev   = samp && act && !m_prev;
            tu   = ev ? 0 : m_t;
            run  = m_locked || ev;
            chk("R1 R2 frm_start", int'(frm_start), int'(ev));
            chk("R11 locked", int'(locked), int'(m_locked));
            chk("R8 misalign", int'(misalign), int'(ev && m_locked && (m_t % ft != 0)));
            if (misalign) mis_seen++;
            for (int i = 0; i < NRX; i++) begin
                int d = f_dly(rx_rate[i], rx_slot_off[i], rx_bit_off[i], rx_frac[i]);
                int tpb = f_tpb(rx_rate[i]);
                int c = f_cur(tu, d, ft);
                chk("R5 R6 R9 R10 rx_slot", int'(rx_slot[i]), run ? c / (8 * tpb) : 0);
                chk("R5 R6 R10 rx_bit", int'(rx_bit[i]), run ? (c / tpb) % 8 : 0);
                chk("R3 R7 rx_smp", int'(rx_smp[i]), int'(run && (c % tpb == 0)));
            end
            for (int i = 0; i < NTX; i++) begin
                int d = f_dly(tx_rate[i], tx_slot_off[i], tx_bit_off[i], tx_frac[i]);
                int tpb = f_tpb(tx_rate[i]);
                int c = f_cur(tu, d, ft);
                int b = (c / tpb) % 8;
                chk("R5 R6 R10 tx_slot", int'(tx_slot[i]), run ? c / (8 * tpb) : 0);
                chk("R5 R6 tx_bit", int'(tx_bit[i]), run ? b : 0);
                chk("R4 R7 tx_shift", int'(tx_shift[i]), int'(run && (c % tpb == 0)));
                chk("R4 txd", int'(txd[i]), run ? int'(tx_byte[i][7 - b]) : 0);
            end
            m_t = tu + 1;
            if (ev) m_locked = 1;
            if (samp) m_prev = act;
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        // directed: zero offsets R3 R4, 3/4-bit at CK/2 and 1-bit at CK/4 (R7)
        fs_pol = 1; fs_rise = 1; frm_len = FW'(32);
        rx_rate[0] = 0; rx_rate[1] = 1; rx_frac[1] = 3;
        tx_rate[0] = 2; tx_bit_off[0] = 1; tx_rate[1] = 0;
        tx_byte[0] = 8'hA5; tx_byte[1] = 8'h3C;
        do_reset();
        run_ticks(200, 6, 6 + 64, -1);
        // active-low sync on falling edge (R1 R2), per-highway independence R5
        fs_pol = 0; fs_rise = 0; frm_len = FW'(64);
        rx_slot_off[0] = 2; rx_bit_off[1] = 5; tx_slot_off[1] = 3; tx_frac[0] = 2;
        do_reset();
        run_ticks(300, 9, -1, -1);
        // off-boundary sync raises misalign once (R8)
        fs_pol = 1; fs_rise = 1; frm_len = FW'(32);
        do_reset();
        run_ticks(220, 5, 5 + 64, 5 + 64 + 17);
        chk("R8 misalign seen", mis_seen, 1);
        // random configurations
        for (int s = 0; s < 25; s++) begin
            int ft;
            frm_len = FW'(32 * (1 + $urandom_range(0, 2)));
            ft = 2 * int'(frm_len);
            fs_pol = 1'($urandom_range(0, 1));
            fs_rise = 1'($urandom_range(0, 1));
            for (int i = 0; i < NRX; i++) begin
                rx_rate[i] = 2'($urandom_range(0, 2));
                rx_slot_off[i] = SW'($urandom_range(0, ft / (8 * f_tpb(rx_rate[i])) - 1));
                rx_bit_off[i] = 3'($urandom_range(0, 7));
                rx_frac[i] = 2'($urandom_range(0, 3));
            end
            for (int i = 0; i < NTX; i++) begin
                tx_rate[i] = 2'($urandom_range(0, 2));
                tx_slot_off[i] = SW'($urandom_range(0, ft / (8 * f_tpb(tx_rate[i])) - 1));
                tx_bit_off[i] = 3'($urandom_range(0, 7));
                tx_frac[i] = 2'($urandom_range(0, 3));
                tx_byte[i] = 8'($urandom_range(0, 255));
            end
            do_reset();
            run_ticks(3 * ft, 3, 3 + ft, ($urandom_range(0, 1) == 1) ? 3 + ft + 11 : -1);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule